// File: doc/BRIEF.md
# Read-Before-Write Protected Condition Register

This block holds an 8-bit condition register whose bits are raised by single-cycle hardware event pulses and cleared by a host over a simple register bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. Every host read of the condition register also copies the value returned into a comparison register. On a later host write, a bit takes the written data only if its live value still equals its copy. A bit that has changed since the read keeps its value. This means an event that lands between the host's read and its clearing write is never erased.

When a host write to the condition register finds at least one bit that differs from its comparison copy, the block sets a conditional-write-inhibit flag. The flag sits in a separate interrupt condition register and is also driven out as a pin. The host clears the flag by writing 0, and that write follows the same read-then-write rule, using a one-bit copy taken when the interrupt condition register is read. The host can read and load the comparison register directly. Two addresses next to it are reserved.

Host accesses are classified by a decoder into named access kinds. ACC_IDLE means no access, or a write to an unmapped address. ACC_RD_STAT, ACC_RD_CMP and ACC_RD_ICR are reads of the three registers, and ACC_RD_NONE is a read of any other address. ACC_WR_STAT, ACC_WR_CMP and ACC_WR_ICR are writes to the three registers. Each cycle goes straight from the idle kind to exactly one access kind, set by the strobes and address, and returns to idle when both strobes are low. When both strobes are high, the write kind is chosen.

Top module: `cond_protect_regs`

## Requirements
- R1: A read of address 1Ch returns the condition register on rd_data_o in the cycle after the strobe and copies that same value into the comparison register.
- R2: On a write to 1Ch, every bit whose current value equals its comparison bit takes the written data bit.
- R3: On a write to 1Ch, every bit whose current value differs from its comparison bit keeps its current value.
- R4: A write to 1Ch that finds any differing bit sets the inhibit flag, which is bit 0 of the interrupt condition register at 1Ah and also drives cwi_o. Bits 7..1 of 1Ah read as 0.
- R5: The inhibit flag stays set until a write to 1Ah loads it from data bit 0. That write takes effect only if the flag equals the one-bit copy taken at the last read of 1Ah.
- R6: The comparison register at 1Dh is always readable, and a write there loads it with no inhibit check and no change to the flag.
- R7: Addresses 1Eh and 1Fh read as 00h, and writes to them change no register.
- R8: An event pulse on evt_i[i] sets condition bit i, and this holds even when a host write clears that bit in the same cycle.
- R9: A synchronous active-high reset clears the condition register, the comparison register and the inhibit flag.
- R10: Condition bit order from bit 0 to bit 7 is: idle line state, state threshold, active line state, line-state-unknown PHY valid, cascade sync error, elastic buffer over/underflow, super idle line state, spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 5 | Register address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 8 | Write data |
| evt_i | input | 8 | Hardware event pulses, one per condition bit |
| rd_data_o | output | 8 | Read data, valid the cycle after the read strobe |
| cwi_o | output | 1 | Conditional-write-inhibit flag |

## Verification
The assertions assume the read and write strobes are never high in the same cycle. They also assume that event pulses do not arrive in the same cycle as a write to a reserved address. The directed tasks issue one access per cycle and only raise event lines either on their own or together with a write to 1Ch. A bench model applies the per-bit write rule, so collisions between events, the snapshot and clearing writes can be staged in any order.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

    localparam int ADDR_ICR  = 'h1A;
    localparam int ADDR_STAT = 'h1C;
    localparam int ADDR_CMP  = 'h1D;
    localparam int ADDR_RSV0 = 'h1E;
    localparam int ADDR_RSV1 = 'h1F;

    localparam int CWI_BIT = 0;

    // condition bit positions (bit index is the event line index)
    typedef enum int {
        SB_IDLE_LS     = 0,
        SB_THRESH      = 1,
        SB_ACTIVE_LS   = 2,
        SB_LS_UNK_PHY  = 3,
        SB_CASC_SYNC   = 4,
        SB_EBUF_OU     = 5,
        SB_SUPER_IDLE  = 6,
        SB_SPARE       = 7
    } stat_bit_e;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_STAT,
        ACC_RD_CMP,
        ACC_RD_ICR,
        ACC_RD_NONE,
        ACC_WR_STAT,
        ACC_WR_CMP,
        ACC_WR_ICR
    } acc_e;

endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
    import cpr_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] addr_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    output acc_e          acc_o
);

    always_comb begin
        acc_o = ACC_IDLE;
        unique case ({wr_en_i, rd_en_i})
            2'b10, 2'b11: begin
                if (addr_i == AW'(ADDR_STAT))      acc_o = ACC_WR_STAT;
                else if (addr_i == AW'(ADDR_CMP))  acc_o = ACC_WR_CMP;
                else if (addr_i == AW'(ADDR_ICR))  acc_o = ACC_WR_ICR;
                else                               acc_o = ACC_IDLE;
            end
            2'b01: begin
                if (addr_i == AW'(ADDR_STAT))      acc_o = ACC_RD_STAT;
                else if (addr_i == AW'(ADDR_CMP))  acc_o = ACC_RD_CMP;
                else if (addr_i == AW'(ADDR_ICR))  acc_o = ACC_RD_ICR;
                else                               acc_o = ACC_RD_NONE;
            end
            default: acc_o = ACC_IDLE;
        endcase
    end

endmodule

// File: rtl/cpr_status.sv
module cpr_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stat_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] evt_i,
    input  logic [DW-1:0] cmp_i,
    output logic [DW-1:0] stat_o,
    output logic          inhibit_o
);

    logic [DW-1:0] moved;
    logic [DW-1:0] stat_nx;

    assign moved     = stat_o ^ cmp_i;
    assign inhibit_o = wr_stat_i && (moved != '0);

    for (genvar gi = 0; gi < DW; gi++) begin : g_bit
        always_comb begin
            stat_nx[gi] = stat_o[gi];
            if (wr_stat_i && !moved[gi]) begin
                stat_nx[gi] = wdata_i[gi];
            end
            if (evt_i[gi]) begin
                stat_nx[gi] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_o <= '0;
        else     stat_o <= stat_nx;
    end

    assert_match_takes_data_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stat_i |=> ((stat_o & ~$past(moved) & ~$past(evt_i)) ==
                       ($past(wdata_i) & ~$past(moved) & ~$past(evt_i))));

    assert_moved_bit_holds_R3: assert property (@(posedge clk) disable iff (rst)
        wr_stat_i |=> ((stat_o & $past(moved)) ==
                       (($past(stat_o) | $past(evt_i)) & $past(moved))));

    assert_event_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/cpr_snap.sv
module cpr_snap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_stat_i,
    input  logic [DW-1:0] stat_i,
    input  logic          load_host_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] cmp_o
);

    always_ff @(posedge clk) begin
        if (rst)              cmp_o <= '0;
        else if (load_host_i) cmp_o <= wdata_i;
        else if (load_stat_i) cmp_o <= stat_i;
    end

    assert_host_load_R6: assert property (@(posedge clk) disable iff (rst)
        load_host_i |=> (cmp_o == $past(wdata_i)));

endmodule

// File: rtl/cpr_icr.sv
module cpr_icr (
    input  logic clk,
    input  logic rst,
    input  logic inhibit_i,
    input  logic rd_icr_i,
    input  logic wr_icr_i,
    input  logic wbit_i,
    output logic cwi_o
);

    logic cwi_snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwi_o    <= 1'b0;
            cwi_snap <= 1'b0;
        end else begin
            if (rd_icr_i) cwi_snap <= cwi_o;
            if (inhibit_i)                          cwi_o <= 1'b1;
            else if (wr_icr_i && cwi_o == cwi_snap) cwi_o <= wbit_i;
        end
    end

    assert_inhibit_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> cwi_o);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (cwi_o && !wr_icr_i) |=> cwi_o);

    assert_flag_write_guarded_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_icr_i && cwi_o != cwi_snap) |=> (cwi_o == $past(cwi_o)));

endmodule

// File: rtl/cond_protect_regs.sv
module cond_protect_regs
    import cpr_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [DW-1:0] evt_i,
    output logic [DW-1:0] rd_data_o,
    output logic          cwi_o
);

    acc_e          acc;
    logic [DW-1:0] stat;
    logic [DW-1:0] cmp;
    logic          inhibit;
    logic [DW-1:0] icr_word;
    logic [DW-1:0] rd_mux;

    cpr_decode #(.AW(AW)) decode_i (
        .addr_i  (addr_i),
        .rd_en_i (rd_en_i),
        .wr_en_i (wr_en_i),
        .acc_o   (acc)
    );

    cpr_status #(.DW(DW)) status_i (
        .clk       (clk),
        .rst       (rst),
        .wr_stat_i (acc == ACC_WR_STAT),
        .wdata_i   (wr_data_i),
        .evt_i     (evt_i),
        .cmp_i     (cmp),
        .stat_o    (stat),
        .inhibit_o (inhibit)
    );

    cpr_snap #(.DW(DW)) snap_i (
        .clk         (clk),
        .rst         (rst),
        .load_stat_i (acc == ACC_RD_STAT),
        .stat_i      (stat),
        .load_host_i (acc == ACC_WR_CMP),
        .wdata_i     (wr_data_i),
        .cmp_o       (cmp)
    );

    cpr_icr icr_i (
        .clk       (clk),
        .rst       (rst),
        .inhibit_i (inhibit),
        .rd_icr_i  (acc == ACC_RD_ICR),
        .wr_icr_i  (acc == ACC_WR_ICR),
        .wbit_i    (wr_data_i[CWI_BIT]),
        .cwi_o     (cwi_o)
    );

    always_comb begin
        icr_word          = '0;
        icr_word[CWI_BIT] = cwi_o;
    end

    always_comb begin
        unique case (acc)
            ACC_RD_STAT: rd_mux = stat;
            ACC_RD_CMP:  rd_mux = cmp;
            ACC_RD_ICR:  rd_mux = icr_word;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data_o <= '0;
        else     rd_data_o <= rd_mux;
    end

    logic rsv_hit;
    assign rsv_hit = (addr_i == AW'(ADDR_RSV0)) || (addr_i == AW'(ADDR_RSV1));

    assert_read_snapshots_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i && addr_i == AW'(ADDR_STAT)) |=>
            (cmp == $past(stat) && rd_data_o == $past(stat)));

    assert_cmp_write_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == AW'(ADDR_CMP)) |=> (cwi_o == $past(cwi_o)));

    assert_reserved_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i && rsv_hit) |=> (rd_data_o == '0));

    assert_reserved_write_inert_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && rsv_hit && evt_i == '0) |=>
            ($stable(stat) && $stable(cmp) && $stable(cwi_o)));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat == '0 && cmp == '0 && !cwi_o));

endmodule

// File: tb/cond_protect_regs_tb.sv
module cond_protect_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] addr_i = '0;
    logic       rd_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] evt_i = '0;
    logic [7:0] rd_data_o;
    logic       cwi_o;

    int checks = 0;
    int fails  = 0;

    // bench model, built from the requirements
    logic [7:0] m_stat = '0;
    logic [7:0] m_cmp  = '0;
    logic       m_cwi  = 1'b0;
    logic       m_snap = 1'b0;

    always #2 clk = ~clk;

    cond_protect_regs dut_i (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .evt_i     (evt_i),
        .rd_data_o (rd_data_o),
        .cwi_o     (cwi_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [4:0] a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        addr_i  = a;
        rd_en_i = 1'b1;
        case (a)
            5'h1C:   begin exp = m_stat; m_cmp = m_stat; end
            5'h1D:   exp = m_cmp;
            5'h1A:   begin exp = {7'b0, m_cwi}; m_snap = m_cwi; end
            default: exp = 8'h00;
        endcase
        @(negedge clk);
        rd_en_i = 1'b0;
        chk(req, rd_data_o, exp);
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d, input logic [7:0] e);
        logic [7:0] mv;
        @(negedge clk);
        addr_i    = a;
        wr_data_i = d;
        wr_en_i   = 1'b1;
        evt_i     = e;
        case (a)
            5'h1C: begin
                mv     = m_stat ^ m_cmp;
                if (mv != 8'h00) m_cwi = 1'b1;
                m_stat = ((m_stat & mv) | (d & ~mv)) | e;
            end
            5'h1D: begin m_cmp = d; m_stat = m_stat | e; end
            5'h1A: begin
                if (m_cwi == m_snap) m_cwi = d[0];
                m_stat = m_stat | e;
            end
            default: m_stat = m_stat | e;
        endcase
        @(negedge clk);
        wr_en_i = 1'b0;
        evt_i   = '0;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        evt_i  = e;
        m_stat = m_stat | e;
        @(negedge clk);
        evt_i  = '0;
    endtask

    task automatic t_reset;
        chk("R9 flag after reset", {7'b0, cwi_o}, 8'h00);
        do_read(5'h1C, "R9 condition reg after reset");
        do_read(5'h1D, "R9 comparison reg after reset");
        do_read(5'h1A, "R9 interrupt reg after reset");
    endtask

    task automatic t_bit_order;
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1 << i));
            do_read(5'h1C, $sformatf("R10 event line %0d lands on bit %0d", i, i));
        end
    endtask

    task automatic t_snapshot;
        pulse(8'h00);
        do_read(5'h1C, "R1 read returns condition reg");
        do_read(5'h1D, "R1 comparison holds read value");
    endtask

    task automatic t_clear_after_read;
        do_read(5'h1C, "R1 read before clear");
        do_write(5'h1C, 8'h00, 8'h00);
        do_read(5'h1C, "R2 matching bits take written data");
        chk("R4 no flag on clean write", {7'b0, cwi_o}, 8'h00);
    endtask

    task automatic t_collision;
        pulse(8'h01);
        do_read(5'h1C, "R1 read after first event");
        pulse(8'h20);
        do_write(5'h1C, 8'h00, 8'h00);
        chk("R4 flag pin after blocked write", {7'b0, cwi_o}, 8'h01);
        do_read(5'h1C, "R3 moved bit keeps value");
        do_read(5'h1A, "R4 flag in interrupt reg bit 0");
        do_write(5'h1A, 8'h00, 8'h00);
        chk("R5 flag cleared after read then write 0", {7'b0, cwi_o}, 8'h00);
    endtask

    task automatic t_icr_protect;
        do_read(5'h1A, "R5 interrupt reg reads clear flag");
        do_write(5'h1D, 8'h00, 8'h00);
        pulse(8'h40);
        do_write(5'h1C, 8'h00, 8'h00);
        chk("R4 flag raised again", {7'b0, cwi_o}, 8'h01);
        do_write(5'h1A, 8'h00, 8'h00);
        chk("R5 clear blocked when copy is stale", {7'b0, cwi_o}, 8'h01);
        do_read(5'h1A, "R5 flag still set");
        do_write(5'h1A, 8'h00, 8'h00);
        do_read(5'h1A, "R5 flag cleared after fresh read");
    endtask

    task automatic t_cmp_direct;
        do_write(5'h1D, 8'hA5, 8'h00);
        do_read(5'h1D, "R6 comparison reg direct load");
        chk("R6 direct load leaves flag", {7'b0, cwi_o}, {7'b0, m_cwi});
        do_write(5'h1D, 8'h3C, 8'h00);
        do_read(5'h1D, "R6 second direct load");
    endtask

    task automatic t_reserved;
        do_write(5'h1E, 8'hFF, 8'h00);
        do_write(5'h1F, 8'hFF, 8'h00);
        do_read(5'h1E, "R7 reserved 1Eh reads zero");
        do_read(5'h1F, "R7 reserved 1Fh reads zero");
        do_read(5'h1D, "R7 comparison untouched by reserved writes");
        chk("R7 flag untouched by reserved writes", {7'b0, cwi_o}, {7'b0, m_cwi});
        do_read(5'h1C, "R7 condition reg untouched by reserved writes");
    endtask

    task automatic t_set_wins;
        pulse(8'h08);
        do_read(5'h1C, "R8 read before same-cycle clash");
        do_write(5'h1C, 8'h00, 8'h08);
        do_read(5'h1C, "R8 event beats same-cycle clear");
        do_write(5'h1C, 8'h00, 8'h00);
        do_read(5'h1C, "R2 clear after observing");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bit_order();
        t_snapshot();
        t_clear_after_read();
        t_collision();
        t_icr_protect();
        t_cmp_direct();
        t_reserved();
        t_set_wins();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule